// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for every frame the transmit engine finishes, so the host can inspect the outcome of each transmission after the fact. The engine presents a completion strobe together with four outcome flags: a request for an interrupt on success, a jabber error, an underrun, and an abort after too many collisions. Each accepted completion becomes one entry in a small store of `DEPTH` entries. Entries are presented to the host oldest first.

The host sees the oldest entry as an 8-bit status value on `statusByte`. It retires that entry with a one-cycle write strobe on `statusWr`; the written data is not used. When a completion arrives and no space is free, that completion is dropped. The loss is then reported in the status byte of the entry the host is currently looking at.

Jabber and underrun are fatal to the transmitter. Either one raises `txBlocked`, which stays high until the transmitter reset command `txResetCmd` is given. That command also empties the store. While the store is not empty, `txDoneFlag` is high so that it can feed an interrupt status.

Top module: `tx_status_stack`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `statusByte` is 0x00, and `txDoneFlag` and `txBlocked` are low.
- R2: A non-empty store drives `statusByte` with these fields: bit 7 = 1 (valid), bit 6 = interrupt-on-success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = collision abort, bits 1:0 = 0. All of them are taken from the oldest entry.
- R3: A completion is visible in the cycle after the `txDone` edge. Entries are presented oldest first. A `statusWr` pulse retires the oldest entry, and the next entry appears in the following cycle.
- R4: The store holds `DEPTH` entries (default 4). A completion that arrives when the store is full, with no retire in the same cycle, is discarded. It sets bit 2 of `statusByte` for the entry then on top, and bit 2 stays set until that entry is retired. Later entries show bit 2 = 0.
- R5: When the store is empty, `statusByte` reads 0x00, and a `statusWr` pulse has no effect.
- R6: A completion with the jabber or underrun flag set raises `txBlocked` one cycle later, even if the entry itself is discarded. `txBlocked` then stays high until `txResetCmd`.
- R7: `txResetCmd` empties the store and clears the overflow mark and `txBlocked`. A completion or retire in the same cycle is ignored.
- R8: `txDoneFlag` is high exactly when the store holds at least one entry.
- R9: If a completion and a retire arrive in the same cycle on a full store, the oldest entry is retired and the new one is stored, with no overflow. On an empty store, the completion is stored and the retire is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txDone | input | 1 | Completion strobe from the transmit engine |
| txIntReq | input | 1 | Frame asked for an interrupt on success |
| txJabber | input | 1 | Frame ended with a jabber error |
| txUnderrun | input | 1 | Frame ended with a FIFO underrun |
| txMaxColl | input | 1 | Frame aborted after too many collisions |
| statusWr | input | 1 | Host write to the status port; retires the oldest entry |
| txResetCmd | input | 1 | Transmitter reset command |
| statusByte | output | 8 | Status byte of the oldest entry, 0x00 when empty |
| txDoneFlag | output | 1 | High while entries are pending |
| txBlocked | output | 1 | Transmitter held off by a fatal error |

## Verification
The bench pushes all sixteen flag combinations through the store in order and compares each byte with a reference queue. A wrong bit mapping or a reversed retire order would show up as a mismatched byte.

It overfills the store to check three things: that bit 2 lands only on the current top entry, that it clears on retire, and that the dropped completion never appears. A design that marked the new entry, or wrapped and overwrote old data, would fail here.

It drives a completion and a retire in the same cycle on both a full and an empty store. A design that checked fullness before accounting for the retire would report a false overflow. One that underflowed on the empty store would show garbage or a wrong count.

Finally, it checks that a retire on an empty store changes nothing, that `txBlocked` holds until reset, and that `txResetCmd` takes priority over a completion in the same cycle.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef struct packed {
    logic intReq;
    logic jabber;
    logic underrun;
    logic maxColl;
  } txsEntry_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic flush;
  } txsStrobe_t;
endpackage

// File: rtl/txs_ctrl.sv
module txs_ctrl import txs_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic       pushFatal,
  input  logic       popWr,
  input  logic       txResetCmd,
  output txsStrobe_t strobe,
  output logic       empty,
  output logic       ovfFlag,
  output logic       blocked
);
  localparam int COUNT_W = $clog2(DEPTH + 1);

  logic [COUNT_W-1:0] count;
  logic full;

  assign empty = (count == '0);
  assign full  = (count == COUNT_W'(DEPTH));

  always_comb begin
    strobe.flush = txResetCmd;
    strobe.rdEn  = popWr && !empty && !txResetCmd;
    strobe.wrEn  = pushValid && !txResetCmd && (!full || strobe.rdEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      count   <= '0;
      ovfFlag <= 1'b0;
      blocked <= 1'b0;
    end else begin
      count <= count + COUNT_W'(strobe.wrEn) - COUNT_W'(strobe.rdEn);
      if (strobe.rdEn)
        ovfFlag <= 1'b0;
      else if (pushValid && !strobe.wrEn)
        ovfFlag <= 1'b1;
      if (pushValid && pushFatal)
        blocked <= 1'b1;
    end
  end
endmodule

// File: rtl/txs_data.sv
module txs_data import txs_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  txsStrobe_t strobe,
  input  txsEntry_t  pushEntry,
  input  logic       empty,
  input  logic       ovfFlag,
  output logic [7:0] statusByte
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  txsEntry_t slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  txsEntry_t head;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= nextPtr(wrPtr);
      if (strobe.rdEn) rdPtr <= nextPtr(rdPtr);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        slots[g] <= '0;
      else if (strobe.wrEn && wrPtr == PTR_W'(g))
        slots[g] <= pushEntry;
    end
  end

  assign head = slots[rdPtr];

  always_comb begin
    if (empty)
      statusByte = 8'h00;
    else
      statusByte = {1'b1, head.intReq, head.jabber, head.underrun,
                    head.maxColl, ovfFlag, 2'b00};
  end
endmodule

// File: rtl/tx_status_stack.sv
module tx_status_stack import txs_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txDone,
  input  logic       txIntReq,
  input  logic       txJabber,
  input  logic       txUnderrun,
  input  logic       txMaxColl,
  input  logic       statusWr,
  input  logic       txResetCmd,
  output logic [7:0] statusByte,
  output logic       txDoneFlag,
  output logic       txBlocked
);
  txsStrobe_t strobe;
  txsEntry_t  pushEntry;
  logic       empty;
  logic       ovfFlag;

  assign pushEntry = '{intReq: txIntReq, jabber: txJabber,
                       underrun: txUnderrun, maxColl: txMaxColl};

  txs_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .pushValid(txDone),
    .pushFatal(txJabber | txUnderrun), .popWr(statusWr),
    .txResetCmd(txResetCmd), .strobe(strobe), .empty(empty),
    .ovfFlag(ovfFlag), .blocked(txBlocked)
  );

  txs_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushEntry(pushEntry),
    .empty(empty), .ovfFlag(ovfFlag), .statusByte(statusByte)
  );

  assign txDoneFlag = !empty;
endmodule

// File: rtl/tx_status_stack_chk.sv
module tx_status_stack_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txDone,
  input logic       txJabber,
  input logic       txUnderrun,
  input logic       statusWr,
  input logic       txResetCmd,
  input logic [7:0] statusByte,
  input logic       txDoneFlag,
  input logic       txBlocked
);
  // R5 / R8: an empty store reads zero
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    !txDoneFlag |-> statusByte == 8'h00);

  // R2 / R8: a pending entry carries the valid bit
  a_r2_valid_bit: assert property (@(posedge clk) disable iff (!rstN)
    txDoneFlag |-> statusByte[7]);

  // R2: the two low bits are always zero
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[1:0] == 2'b00);

  // R7: the transmitter reset empties the store and unblocks
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    txResetCmd |=> (!txDoneFlag && !txBlocked));

  // R6: a fatal completion blocks the transmitter
  a_r6_block_set: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && (txJabber || txUnderrun) && !txResetCmd) |=> txBlocked);

  // R6: the block is held until the transmitter reset
  a_r6_block_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txBlocked && !txResetCmd) |=> txBlocked);

  // R5: a retire on an empty store changes nothing
  a_r5_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (!txDoneFlag && statusWr && !txDone && !txResetCmd) |=> !txDoneFlag);

  // R3: an accepted completion on an empty store becomes visible
  a_r3_push_visible: assert property (@(posedge clk) disable iff (!rstN)
    (!txDoneFlag && txDone && !txResetCmd) |=> txDoneFlag);
endmodule

bind tx_status_stack tx_status_stack_chk uChk (
  .clk(clk), .rstN(rstN), .txDone(txDone), .txJabber(txJabber),
  .txUnderrun(txUnderrun), .statusWr(statusWr), .txResetCmd(txResetCmd),
  .statusByte(statusByte), .txDoneFlag(txDoneFlag), .txBlocked(txBlocked)
);

// File: tb/tb_tx_status_stack.sv
module tb_tx_status_stack;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txDone = 1'b0, txIntReq = 1'b0, txJabber = 1'b0;
  logic txUnderrun = 1'b0, txMaxColl = 1'b0;
  logic statusWr = 1'b0, txResetCmd = 1'b0;
  logic [7:0] statusByte;
  logic txDoneFlag, txBlocked;

  int checks = 0;
  int errors = 0;

  logic [3:0] modelQ[$];
  logic modelOvf = 1'b0;
  logic modelBlk = 1'b0;

  always #2 clk = ~clk;

  tx_status_stack #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .txDone(txDone), .txIntReq(txIntReq),
    .txJabber(txJabber), .txUnderrun(txUnderrun), .txMaxColl(txMaxColl),
    .statusWr(statusWr), .txResetCmd(txResetCmd), .statusByte(statusByte),
    .txDoneFlag(txDoneFlag), .txBlocked(txBlocked)
  );

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] expByte();
    if (modelQ.size() == 0) return 8'h00;
    return {1'b1, modelQ[0], modelOvf, 2'b00};
  endfunction

  task automatic compareAll(input string req);
    chk(req, "statusByte", statusByte, expByte());
    chk(req, "txDoneFlag", {7'b0, txDoneFlag}, {7'b0, modelQ.size() != 0});
    chk(req, "txBlocked", {7'b0, txBlocked}, {7'b0, modelBlk});
  endtask

  // flags = {intReq, jabber, underrun, maxColl}
  task automatic step(input logic push, input logic [3:0] flags,
                      input logic pop, input logic rst, input string req);
    logic popEff;
    @(negedge clk);
    txDone = push;
    {txIntReq, txJabber, txUnderrun, txMaxColl} = flags;
    statusWr = pop;
    txResetCmd = rst;
    @(posedge clk);
    if (rst) begin
      modelQ.delete();
      modelOvf = 1'b0;
      modelBlk = 1'b0;
    end else begin
      popEff = pop && modelQ.size() != 0;
      if (popEff) begin
        void'(modelQ.pop_front());
        modelOvf = 1'b0;
      end
      if (push) begin
        if (modelQ.size() < DEPTH) modelQ.push_back(flags);
        else modelOvf = 1'b1;
        if (flags[2] || flags[1]) modelBlk = 1'b1;
      end
    end
    #1;
    txDone = 1'b0; statusWr = 1'b0; txResetCmd = 1'b0;
    compareAll(req);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    compareAll("R1");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    compareAll("R1");

    // R2, R3: every flag combination, filled then drained in order
    for (int base = 0; base < 16; base += DEPTH) begin
      for (int k = 0; k < DEPTH; k++) step(1'b1, 4'(base + k), 1'b0, 1'b0, "R2");
      for (int k = 0; k < DEPTH; k++) step(1'b0, 4'h0, 1'b1, 1'b0, "R3");
      step(1'b0, 4'h0, 1'b0, 1'b1, "R7");
    end

    // R5: retire on an empty store has no effect
    step(1'b0, 4'h0, 1'b1, 1'b0, "R5");
    step(1'b0, 4'h0, 1'b1, 1'b0, "R5");

    // R4: overfill, overflow mark on the top entry only
    for (int k = 0; k < DEPTH; k++) step(1'b1, 4'(k + 8), 1'b0, 1'b0, "R8");
    step(1'b1, 4'h1, 1'b0, 1'b0, "R4");
    step(1'b1, 4'h9, 1'b0, 1'b0, "R4");
    for (int k = 0; k < DEPTH + 1; k++) step(1'b0, 4'h0, 1'b1, 1'b0, "R4");

    // R9: simultaneous push and pop on full and on empty
    for (int k = 0; k < DEPTH; k++) step(1'b1, 4'(k + 1), 1'b0, 1'b0, "R9");
    step(1'b1, 4'hA, 1'b1, 1'b0, "R9");
    for (int k = 0; k < DEPTH; k++) step(1'b0, 4'h0, 1'b1, 1'b0, "R9");
    step(1'b1, 4'h3, 1'b1, 1'b0, "R9");
    step(1'b0, 4'h0, 1'b1, 1'b0, "R9");

    // R6: fatal flags block until transmitter reset
    step(1'b1, 4'b0100, 1'b0, 1'b0, "R6");
    step(1'b0, 4'h0, 1'b1, 1'b0, "R6");
    repeat (3) step(1'b0, 4'h0, 1'b0, 1'b0, "R6");
    step(1'b0, 4'h0, 1'b0, 1'b1, "R6");
    step(1'b1, 4'b0010, 1'b0, 1'b0, "R6");
    step(1'b1, 4'b1001, 1'b0, 1'b0, "R6");

    // R7: reset wins over a same-cycle push
    step(1'b1, 4'hF, 1'b1, 1'b1, "R7");
    step(1'b0, 4'h0, 1'b0, 1'b0, "R7");

    // R6: discarded fatal completion still blocks
    for (int k = 0; k < DEPTH; k++) step(1'b1, 4'b1000, 1'b0, 1'b0, "R6");
    step(1'b1, 4'b0100, 1'b0, 1'b0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule